// File: doc/BRIEF.md
# Tunneled Accelerator Buffer Sequencer

This block is the control shell around a streaming hardware accelerator that sits in a chain of processing stages. Each stage owns an input buffer memory and an output buffer memory. Neighbouring stages coordinate through two short messages. A "fill request" asks the stage upstream to deliver another buffer. A "buffer ready" tells the stage downstream that a complete buffer is waiting for it. The sequencer receives these messages and emits them, starts the core on each new input buffer, and decides when the core may store results.

Software first programs the upstream target address, the downstream target address and the buffer length in words, then writes the activation command. From then on the sequencer works without intervention. It asks upstream for data and starts the core once a buffer has arrived. As soon as the core has read its last input word, it asks upstream for the next buffer, so that the next transfer overlaps the current computation. It closes the output buffer when the core writes its last result word, and it reopens the output buffer when the downstream stage asks for more.

Top module: `tun_buf_seq`

## Requirements
- R1: After a synchronous reset, `tx_valid`, `core_start`, `wr_allow` and `rx_ready` are all 0.
- R2: Until the activation command (a configuration write with selector 3 and data bit 0 set) is received, no message is sent, `rx_ready` stays 0 and the core is not started, whatever else is written to configuration.
- R3: After activation, the first outgoing message is a fill request (type code 0) to the upstream address (selector 0).
- R4: The core is started with a one-cycle `core_start` pulse in the cycle after a buffer-ready message (type code 1) is accepted while the sequencer waits for input. At that point `core_word_count` equals the length register (selector 2).
- R5: A `core_in_last` pulse while the core runs causes a fill request to the upstream address, even though the core has not yet finished writing its output.
- R6: `core_start` is never high in two consecutive cycles, and a single buffer-ready starts the core once.
- R7: `wr_allow` is 1 while the output buffer is free. A `core_out_last` pulse makes it 0 from the next cycle on, and it causes a buffer-ready message (type code 1) to the downstream address (selector 1).
- R8: Once the output buffer has been closed, `wr_allow` stays 0 until a fill-request message from downstream is accepted. It becomes 1 in the cycle after that acceptance.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, the type and address of the outgoing message stay unchanged.
- R10: When a fill request and a buffer-ready wait to be sent at the same time, the fill request is sent first.
- R11: A buffer-ready message that arrives while the core is running does not start it. A `core_out_last` pulse while the output buffer is closed sends no message and leaves `wr_allow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 upstream address, 1 downstream address, 2 length, 3 activate |
| cfg_wdata | input | ADDR_W | Configuration write data |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Incoming message accepted (high once active) |
| rx_type | input | 1 | Incoming type: 0 fill request, 1 buffer ready |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Outgoing message taken |
| tx_type | output | 1 | Outgoing type: 0 fill request, 1 buffer ready |
| tx_addr | output | ADDR_W | Target address of outgoing message |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_word_count | output | LEN_W | Number of input words the core consumes |
| core_in_last | input | 1 | Core has read its final input word |
| core_out_last | input | 1 | Core has written its final output word |
| wr_allow | output | 1 | Core may write result words into output memory |

## Verification
The full buffer round is run with several sets of addresses and lengths. This shows that each message goes to the correct neighbour and that the word count follows the register, not a fixed value. A pattern in which the input side and the output side finish in the same cycle, with the outgoing port stalled, separates the priority order from the hold behaviour under backpressure. Stray buffer-ready messages during processing, and extra end-of-output pulses while the output is closed, show that events in the wrong state have no effect. Configuration traffic before activation shows that the block stays silent until the command arrives.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic {MSG_FILL = 1'b0, MSG_READY = 1'b1} msg_e;
  typedef enum logic [1:0] {CFG_UP = 2'd0, CFG_DN = 2'd1, CFG_LEN = 2'd2, CFG_GO = 2'd3} cfg_e;
  typedef enum logic [1:0] {IN_OFF, IN_REQ, IN_WAIT, IN_RUN} in_st_e;
  typedef enum logic [1:0] {OUT_OFF, OUT_FREE, OUT_SEND, OUT_HELD} out_st_e;
endpackage

// File: rtl/tbs_cfg.sv
module tbs_cfg
  import tbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] up_addr,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [LEN_W-1:0]  len,
  output logic              active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up_addr <= '0;
      dn_addr <= '0;
      len     <= '0;
      active  <= 1'b0;
    end else if (we) begin
      case (cfg_e'(sel))
        CFG_UP:  up_addr <= wdata;
        CFG_DN:  dn_addr <= wdata;
        CFG_LEN: len     <= wdata[LEN_W-1:0];
        CFG_GO:  if (wdata[0]) active <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tbs_in_fsm.sv
module tbs_in_fsm
  import tbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic buf_rdy,
  input  logic in_last,
  input  logic grant,
  output logic req,
  output logic start
);
  in_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= IN_OFF;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      case (st)
        IN_OFF:  if (active) st <= IN_REQ;
        IN_REQ:  if (grant) st <= IN_WAIT;
        IN_WAIT: if (buf_rdy) begin
          st    <= IN_RUN;
          start <= 1'b1;
        end
        IN_RUN:  if (in_last) st <= IN_REQ;
        default: st <= IN_OFF;
      endcase
    end
  end

  assign req = (st == IN_REQ);
endmodule

// File: rtl/tbs_out_fsm.sv
module tbs_out_fsm
  import tbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic out_last,
  input  logic grant,
  input  logic fill_in,
  output logic req,
  output logic wr_allow
);
  out_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= OUT_OFF;
    end else begin
      case (st)
        OUT_OFF:  if (active) st <= OUT_FREE;
        OUT_FREE: if (out_last) st <= OUT_SEND;
        OUT_SEND: if (grant) st <= OUT_HELD;
        OUT_HELD: if (fill_in) st <= OUT_FREE;
        default:  st <= OUT_OFF;
      endcase
    end
  end

  assign req      = (st == OUT_SEND);
  assign wr_allow = (st == OUT_FREE);
endmodule

// File: rtl/tbs_tx_arb.sv
module tbs_tx_arb
  import tbs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter bit FILL_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_req,
  input  logic              rdy_req,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [ADDR_W-1:0] dn_addr,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_type,
  output logic [ADDR_W-1:0] tx_addr,
  output logic              grant_fill,
  output logic              grant_rdy
);
  logic load_ok;
  msg_e type_q;

  assign load_ok = !tx_valid || tx_ready;

  generate
    if (FILL_FIRST) begin : g_fill_first
      assign grant_fill = load_ok && fill_req;
      assign grant_rdy  = load_ok && rdy_req && !fill_req;
    end else begin : g_rdy_first
      assign grant_rdy  = load_ok && rdy_req;
      assign grant_fill = load_ok && fill_req && !rdy_req;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      type_q   <= MSG_FILL;
      tx_addr  <= '0;
    end else if (load_ok) begin
      tx_valid <= grant_fill || grant_rdy;
      if (grant_fill) begin
        type_q  <= MSG_FILL;
        tx_addr <= up_addr;
      end else if (grant_rdy) begin
        type_q  <= MSG_READY;
        tx_addr <= dn_addr;
      end
    end
  end

  assign tx_type = type_q;
endmodule

// File: rtl/tun_buf_seq.sv
module tun_buf_seq
  import tbs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter bit FILL_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_type,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_type,
  output logic [ADDR_W-1:0] tx_addr,
  output logic              core_start,
  output logic [LEN_W-1:0]  core_word_count,
  input  logic              core_in_last,
  input  logic              core_out_last,
  output logic              wr_allow
);
  logic [ADDR_W-1:0] up_addr, dn_addr;
  logic active, rx_fire, fill_req, rdy_req, grant_fill, grant_rdy;

  tbs_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .up_addr(up_addr), .dn_addr(dn_addr), .len(core_word_count), .active(active)
  );

  assign rx_ready = active;
  assign rx_fire  = rx_valid && active;

  tbs_in_fsm in_i (
    .clk(clk), .rst(rst), .active(active),
    .buf_rdy(rx_fire && (rx_type == MSG_READY)),
    .in_last(core_in_last), .grant(grant_fill),
    .req(fill_req), .start(core_start)
  );

  tbs_out_fsm out_i (
    .clk(clk), .rst(rst), .active(active),
    .out_last(core_out_last), .grant(grant_rdy),
    .fill_in(rx_fire && (rx_type == MSG_FILL)),
    .req(rdy_req), .wr_allow(wr_allow)
  );

  tbs_tx_arb #(.ADDR_W(ADDR_W), .FILL_FIRST(FILL_FIRST)) arb_i (
    .clk(clk), .rst(rst), .fill_req(fill_req), .rdy_req(rdy_req),
    .up_addr(up_addr), .dn_addr(dn_addr), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_type(tx_type), .tx_addr(tx_addr),
    .grant_fill(grant_fill), .grant_rdy(grant_rdy)
  );
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_type,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_type,
  input logic [ADDR_W-1:0] tx_addr,
  input logic              core_start,
  input logic              core_out_last,
  input logic              wr_allow
);
  // R2: nothing happens before activation
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |-> (!tx_valid && !core_start && !wr_allow));

  // R4: a start is always preceded by an accepted buffer-ready
  p_start_after_ready_r4: assert property (@(posedge clk) disable iff (rst)
    core_start |-> $past(rx_valid && rx_ready && rx_type));

  // R6: start is a single-cycle pulse
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  // R7: end of output closes the output buffer
  p_out_close_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_allow && core_out_last) |=> !wr_allow);

  // R9: stalled outgoing message is held
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_type) && $stable(tx_addr)));
endmodule

bind tun_buf_seq tbs_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_type(rx_type), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_type(tx_type), .tx_addr(tx_addr), .core_start(core_start),
  .core_out_last(core_out_last), .wr_allow(wr_allow)
);

// File: tb/tun_buf_seq_tb_top.sv
module tun_buf_seq_tb_top;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int NVEC   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic rx_valid = 1'b0, rx_type = 1'b0, tx_ready = 1'b0;
  logic core_in_last = 1'b0, core_out_last = 1'b0;
  logic rx_ready, tx_valid, tx_type, core_start, wr_allow;
  logic [ADDR_W-1:0] tx_addr;
  logic [LEN_W-1:0] core_word_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {upstream address, downstream address, length}
  localparam logic [2*ADDR_W+LEN_W-1:0] VEC [NVEC] = '{
    {16'h1200, 16'h3400, 12'd64},
    {16'hA5C3, 16'h0001, 12'd1},
    {16'h0FF0, 16'hFFFF, 12'd4095}
  };

  always #5 clk = ~clk;

  tun_buf_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_addr(tx_addr),
    .core_start(core_start), .core_word_count(core_word_count),
    .core_in_last(core_in_last), .core_out_last(core_out_last), .wr_allow(wr_allow)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send_rx(input logic typ);
    rx_valid = 1'b1; rx_type = typ;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(input logic typ, input logic [ADDR_W-1:0] addr, input string req);
    for (int i = 0; i < 20; i++) begin
      if (tx_valid) break;
      step();
    end
    chk(tx_valid == 1'b1, req, int'(tx_valid), 1);
    chk(tx_type == typ, req, int'(tx_type), int'(typ));
    chk(tx_addr == addr, req, int'(tx_addr), int'(addr));
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
  endtask

  task automatic pulse_in();
    core_in_last = 1'b1; step(); core_in_last = 1'b0;
  endtask

  task automatic pulse_out();
    core_out_last = 1'b1; step(); core_out_last = 1'b0;
  endtask

  task automatic setup(input logic [ADDR_W-1:0] up, input logic [ADDR_W-1:0] dn,
                       input logic [LEN_W-1:0] len);
    do_reset();
    cfg_write(2'd0, up);
    cfg_write(2'd1, dn);
    cfg_write(2'd2, ADDR_W'(len));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(tx_valid == 1'b0, "R1", int'(tx_valid), 0);
    chk(core_start == 1'b0, "R1", int'(core_start), 0);
    chk(wr_allow == 1'b0, "R1", int'(wr_allow), 0);
    chk(rx_ready == 1'b0, "R1", int'(rx_ready), 0);

    // Table of full buffer rounds
    for (int v = 0; v < NVEC; v++) begin
      logic [ADDR_W-1:0] up, dn;
      logic [LEN_W-1:0] len;
      {up, dn, len} = VEC[v];
      setup(up, dn, len);
      repeat (3) step();
      chk(tx_valid == 1'b0, "R2", int'(tx_valid), 0);
      chk(rx_ready == 1'b0, "R2", int'(rx_ready), 0);
      cfg_write(2'd3, 16'h0001);
      wait_tx(1'b0, up, "R3");
      chk(core_start == 1'b0, "R4", int'(core_start), 0);
      send_rx(1'b1);
      chk(core_start == 1'b1, "R4", int'(core_start), 1);
      chk(core_word_count == len, "R4", int'(core_word_count), int'(len));
      step();
      chk(core_start == 1'b0, "R6", int'(core_start), 0);
      chk(wr_allow == 1'b1, "R7", int'(wr_allow), 1);
      pulse_in();
      wait_tx(1'b0, up, "R5");
      chk(wr_allow == 1'b1, "R5", int'(wr_allow), 1);
      pulse_out();
      chk(wr_allow == 1'b0, "R7", int'(wr_allow), 0);
      wait_tx(1'b1, dn, "R7");
      repeat (2) step();
      chk(wr_allow == 1'b0, "R8", int'(wr_allow), 0);
      send_rx(1'b0);
      chk(wr_allow == 1'b1, "R8", int'(wr_allow), 1);
    end

    // R10 and R9: both sides finish together with the port stalled
    setup(16'h0AAA, 16'h0BBB, 12'd8);
    cfg_write(2'd3, 16'h0001);
    wait_tx(1'b0, 16'h0AAA, "R3");
    send_rx(1'b1);
    step();
    core_in_last = 1'b1; core_out_last = 1'b1;
    step();
    core_in_last = 1'b0; core_out_last = 1'b0;
    repeat (3) step();
    chk(tx_valid == 1'b1, "R10", int'(tx_valid), 1);
    chk(tx_type == 1'b0, "R10", int'(tx_type), 0);
    repeat (3) step();
    chk(tx_type == 1'b0, "R9", int'(tx_type), 0);
    chk(tx_addr == 16'h0AAA, "R9", int'(tx_addr), 16'h0AAA);
    wait_tx(1'b0, 16'h0AAA, "R10");
    wait_tx(1'b1, 16'h0BBB, "R10");

    // R11: output closed, extra end-of-output pulse ignored
    pulse_out();
    repeat (3) step();
    chk(tx_valid == 1'b0, "R11", int'(tx_valid), 0);
    chk(wr_allow == 1'b0, "R11", int'(wr_allow), 0);
    // R11 / R6: stray buffer-ready while running does not restart
    send_rx(1'b1);
    chk(core_start == 1'b1, "R6", int'(core_start), 1);
    step();
    send_rx(1'b1);
    chk(core_start == 1'b0, "R11", int'(core_start), 0);
    step();
    chk(core_start == 1'b0, "R11", int'(core_start), 0);
    chk(tx_valid == 1'b0, "R11", int'(tx_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule